// File: doc/BRIEF.md
# Modem Status Edge Event Detector

This block sits beside a UART and watches the four modem-status input lines: clear-to-send, carrier detect, data-set-ready and ring indicator. Each raw line is brought into the clock domain through a two-flop synchroniser, and the synchronised levels can be read at any time as separate bits.

Only the clear-to-send and carrier-detect lines can raise events. Software turns event capture on for each of these two lines separately. A second control per line chooses how the line is watched: with it clear, only a rising edge counts; with it set, a change in either direction counts. A captured change sets a sticky event bit for that line. The block drives one request, which is high while any event bit is set, toward the UART's main interrupt register.

Software collects the events with a read strobe. During the strobe cycle the read port shows the event bits as they stand, and the strobe clears them at the next clock edge. An edge that is captured in that same cycle survives the clear, so no event is lost between two reads.

Top module: `modem_evt_top`

## Requirements
- R1: `rd_level` bit 0 follows clear-to-send, bit 1 carrier detect, bit 2 data-set-ready and bit 3 ring indicator. Each bit takes the raw line value two rising clock edges after the line changes.
- R2: With `edge_en[i]` high and `any_edge[i]` low, a rising edge on line i (0 = clear-to-send, 1 = carrier detect) sets `rd_event[i]` at the third clock edge after the raw change.
- R3: With `any_edge[i]` low, a falling edge on line i does not set `rd_event[i]`.
- R4: With `edge_en[i]` high and `any_edge[i]` high, a falling edge sets `rd_event[i]` as well as a rising edge does.
- R5: With `edge_en[i]` low, no edge on line i sets `rd_event[i]`, whatever `any_edge[i]` holds.
- R6: Changes on data-set-ready and ring indicator never set an event bit and never raise `ext_irq`.
- R7: While `rd_stb` is high, `rd_event` shows the current event bits. After the clock edge that samples the strobe, those bits read 0 unless a new edge arrived.
- R8: An edge captured in the same cycle as a read strobe leaves its event bit set after that edge.
- R9: Without a read, a set event bit stays set. `ext_irq` is high exactly when at least one event bit is set.
- R10: After reset, `rd_level`, `rd_event` and `ext_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_raw | input | 4 | Raw modem lines, bit 0 clear-to-send, 1 carrier detect, 2 data-set-ready, 3 ring indicator |
| edge_en | input | 2 | Event capture enable per edge-capable line |
| any_edge | input | 2 | 1: either edge counts, 0: rising edge only |
| rd_stb | input | 1 | Read strobe; clears event bits at the next edge |
| rd_level | output | 4 | Synchronised line levels |
| rd_event | output | 2 | Latched event bits |
| ext_irq | output | 1 | Combined event request |

## Verification
The bench runs every combination of line, enable, sense mode and edge direction on the two edge-capable lines. The sweep separates the rising-only mode from the both-edges mode and enabled lines from disabled ones. Toggling the two level-only lines shows that they appear in the level bits but never reach the event path. Two targeted sequences probe read clearing. One clears bits that are already latched. The other lands a fresh edge exactly on the read cycle, which tells a correct clear apart from one that drops the new event.

// File: rtl/modem_evt_pkg.sv
package modem_evt_pkg;

    localparam int LINE_COUNT  = 4;
    localparam int EDGE_COUNT  = 2;
    localparam int SYNC_DEPTH  = 2;

    localparam int IDX_CTS = 0;
    localparam int IDX_DCD = 1;
    localparam int IDX_DSR = 2;
    localparam int IDX_RI  = 3;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic now_lvl, input logic old_lvl);
        edge_t e;
        e.rise = now_lvl & ~old_lvl;
        e.fall = ~now_lvl & old_lvl;
        return e;
    endfunction

    function automatic logic edge_counts(input edge_t e, input logic en, input logic both);
        return en & (e.rise | (both & e.fall));
    endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_edge_cell.sv
module modem_edge_cell
    import modem_evt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic en_i,
    input  logic both_i,
    input  logic clr_i,
    output logic stat_o
);
    logic  prev_q;
    logic  stat_q;
    edge_t seen;
    logic  hit;

    always_comb begin
        seen = edge_of(lvl_i, prev_q);
        hit  = edge_counts(seen, en_i, both_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            stat_q <= (stat_q & ~clr_i) | hit;
        end
    end

    assign stat_o = stat_q;

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i && !hit |=> !stat_o);

    // R8
    keep_new_evt_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> stat_o);

    // R9
    sticky_evt_chk: assert property (@(posedge clk) disable iff (rst)
        stat_o && !clr_i |=> stat_o);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i && !stat_o |=> !stat_o);

    // R3
    no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !both_i && !stat_o && !lvl_i |=> !stat_o);
endmodule

// File: rtl/modem_evt_top.sv
module modem_evt_top
    import modem_evt_pkg::*;
#(
    parameter int LINES      = LINE_COUNT,
    parameter int EDGE_LINES = EDGE_COUNT,
    parameter int STAGES     = SYNC_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINES-1:0]      line_raw,
    input  logic [EDGE_LINES-1:0] edge_en,
    input  logic [EDGE_LINES-1:0] any_edge,
    input  logic                  rd_stb,
    output logic [LINES-1:0]      rd_level,
    output logic [EDGE_LINES-1:0] rd_event,
    output logic                  ext_irq
);
    logic [LINES-1:0]      lvl_sync;
    logic [EDGE_LINES-1:0] evt;

    modem_sync #(.WIDTH(LINES), .STAGES(STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (line_raw),
        .sync_o (lvl_sync)
    );

    for (genvar i = 0; i < EDGE_LINES; i++) begin : g_cell
        modem_edge_cell cell_i (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (lvl_sync[i]),
            .en_i   (edge_en[i]),
            .both_i (any_edge[i]),
            .clr_i  (rd_stb),
            .stat_o (evt[i])
        );
    end

    assign rd_level = lvl_sync;
    assign rd_event = evt;
    assign ext_irq  = |evt;

    // R10
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (rd_level == '0) && (rd_event == '0) && !ext_irq);
endmodule

// File: tb/modem_evt_top_tb_top.sv
module modem_evt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] line_raw = '0;
    logic [1:0] edge_en = '0;
    logic [1:0] any_edge = '0;
    logic       rd_stb = 1'b0;
    logic [3:0] rd_level;
    logic [1:0] rd_event;
    logic       ext_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    modem_evt_top dut_i (
        .clk(clk), .rst(rst), .line_raw(line_raw), .edge_en(edge_en),
        .any_edge(any_edge), .rd_stb(rd_stb), .rd_level(rd_level),
        .rd_event(rd_event), .ext_irq(ext_irq)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_events();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R10 reset state
        check("R10 level", rd_level, 0);
        check("R10 event", rd_event, 0);
        check("R10 irq", ext_irq, 0);

        // R1 level bits and two-edge latency, every pattern
        for (int p = 0; p < 16; p++) begin
            line_raw = p[3:0];
            tick();
            check("R1 not before two edges", rd_level, (p == 0) ? 0 : p - 1);
            tick();
            check("R1 level", rd_level, p);
            line_raw = p[3:0];
        end
        line_raw = '0;
        tick(4);
        clear_events();

        // R2/R3/R4/R5 sweep over line, enable, sense, direction
        for (int ln = 0; ln < 2; ln++)
            for (int en = 0; en < 2; en++)
                for (int both = 0; both < 2; both++)
                    for (int rise = 0; rise < 2; rise++) begin
                        edge_en = '0;
                        any_edge = '0;
                        line_raw[ln] = rise ? 1'b0 : 1'b1;
                        tick(4);
                        clear_events();
                        edge_en[ln] = en[0];
                        any_edge[ln] = both[0];
                        line_raw[ln] = rise[0];
                        tick(2);
                        check("R2 not before third edge", rd_event[ln], 0);
                        tick();
                        begin
                            int exp;
                            exp = en & (rise | both);
                            if (!en) check("R5 disabled edge", rd_event[ln], exp);
                            else if (rise) check("R2 rising edge", rd_event[ln], exp);
                            else if (both) check("R4 falling edge both", rd_event[ln], exp);
                            else check("R3 falling edge ignored", rd_event[ln], exp);
                            check("R9 irq", ext_irq, exp);
                            tick(3);
                            check("R9 sticky", rd_event[ln], exp);
                        end
                        clear_events();
                    end
        line_raw = '0;
        edge_en = '0;
        any_edge = '0;
        tick(4);
        clear_events();

        // R6 data-set-ready and ring indicator never raise events
        edge_en = 2'b11;
        any_edge = 2'b11;
        for (int t = 0; t < 4; t++) begin
            line_raw[3:2] = t[1:0] ^ 2'b01;
            tick(4);
            check("R6 event", rd_event, 0);
            check("R6 irq", ext_irq, 0);
        end
        line_raw = '0;
        tick(4);
        clear_events();

        // R7 read shows bits then clears them
        any_edge = 2'b00;
        line_raw[0] = 1'b1;
        line_raw[1] = 1'b1;
        tick(4);
        rd_stb = 1'b1;
        check("R7 read shows events", rd_event, 3);
        tick();
        rd_stb = 1'b0;
        check("R7 cleared", rd_event, 0);
        check("R7 irq cleared", ext_irq, 0);

        // R8 edge coinciding with the read cycle survives
        line_raw = '0;
        tick(4);
        clear_events();
        line_raw[1] = 1'b1;
        tick(2);
        rd_stb = 1'b1;
        check("R8 before capture", rd_event[1], 0);
        tick();
        rd_stb = 1'b0;
        check("R8 kept", rd_event[1], 1);
        check("R8 other line", rd_event[0], 0);
        check("R8 irq", ext_irq, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule